// File: doc/BRIEF.md
# Interlocked Read Link over a Shared Address/Data Bus

This block joins a reading agent to a small storage unit through one set of lines that carries first an address and then the returned word. Two state machines share the link. The fetch side starts a read and later receives the word. The store side accepts the address, waits a chosen number of access cycles and returns the word. Each side may drive the lines only at its own point in the exchange. Every strobe edge is answered by an edge from the far side, so neither side relies on the timing of the other.

Each side sees the far side's strobes only through a two-stage flip-flop chain, so a reaction comes three cycles after the edge that causes it. A user pulses `start` with an address while `ready` is high. After the full exchange, `done` pulses for one cycle and the word appears on `rd_data`. The shared `ack` wire is the OR of the two sides' acknowledge strobes. Each side watches only the acknowledge driven by the other side.

Fetch side states: FT_IDLE (waits for `start` and a quiet link), FT_ADDR (drives the address and raises the request), FT_WAIT (lines released, waits for data-ready) and FT_ACK (word captured, acknowledge raised). Its transitions are accept, addr_acked, data_seen and rdy_gone.

Store side states: ST_IDLE (waits for the request), ST_ACK (address latched, acknowledge raised), ST_ACCESS (counts access cycles) and ST_DRIVE (drives the word and raises data-ready). Its transitions are req_seen, req_gone, count_done and data_acked.

Top module: `rdhs_link`

## Requirements
- R1: After reset, `read_req`, `ack`, `data_rdy`, both drive flags, `done`, `bus_lines` and `rd_data` are all 0, and `ready` is 1.
- R2: `req_drive` and `rsp_drive` are never 1 in the same cycle, and `bus_lines` is 0 whenever neither of them is 1.
- R3: When `start` is sampled high at a clock edge with `ready` high, `read_req` and `req_drive` are 1 from that edge on. During that time `bus_lines` carries `start_addr` zero-extended to the bus width.
- R4: The store side raises its acknowledge 3 cycles after `read_req` rises, and latches the address present on the lines at that time.
- R5: The fetch side drops `read_req` and `req_drive` 3 cycles after the acknowledge rises. The store side drops its acknowledge 3 cycles after `read_req` falls.
- R6: `data_rdy` and `rsp_drive` rise `access_wait`+1 cycles after the store side's acknowledge falls. While they are high, `bus_lines` carries the stored word, and location i holds i XOR 0xA5.
- R7: The fetch side loads `rd_data` from the lines and raises its acknowledge 3 cycles after `data_rdy` rises. `rd_data` keeps that value until the next capture.
- R8: `data_rdy` and `rsp_drive` fall 3 cycles after the fetch side's acknowledge rises. That acknowledge falls 3 cycles after `data_rdy` falls. On that same edge `done` pulses for one cycle and `ready` returns to 1.
- R9: `start` has no effect while `ready` is 0. Changes on `start_addr` after a read is accepted do not alter the address or the word of that read.
- R10: `access_wait` is sampled when the store side leaves its acknowledge state. A value of 0 gives the shortest access of one cycle, and the largest value gives the longest access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a read |
| start_addr | input | AW | Address of the read |
| access_wait | input | WW | Extra access cycles inserted by the store side |
| ready | output | 1 | Fetch side idle and link quiet; a start is accepted |
| done | output | 1 | One-cycle pulse at the end of a read |
| rd_data | output | DW | Last word received |
| read_req | output | 1 | Request strobe on the link |
| ack | output | 1 | Shared acknowledge wire (OR of both sides) |
| data_rdy | output | 1 | Data-ready strobe on the link |
| req_drive | output | 1 | Fetch side drives the shared lines |
| rsp_drive | output | 1 | Store side drives the shared lines |
| bus_lines | output | DW | Value on the shared lines |

## Verification
The bench keeps a timeline model of the exchange and checks every strobe, both drive flags and the lines on every cycle. An off-by-one in a synchronizer chain or in the access counter therefore shows up as a shifted edge, not only as a late `done`. Zero and maximum access waits are both run. Zero exposes a counter that wraps on underflow, and the maximum exposes a counter that is too narrow or is loaded from the wrong cycle. Extra start pulses and address changes are sent during a read; a design that does not gate the start, or that reads `start_addr` directly, would restart the read or return the wrong word. Holding `start` high across reads checks that the next read begins exactly when the previous data-ready is seen low, not earlier while the link is still busy.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

    typedef enum logic [1:0] {
        FT_IDLE,
        FT_ADDR,
        FT_WAIT,
        FT_ACK
    } fetch_state_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACK,
        ST_ACCESS,
        ST_DRIVE
    } store_state_t;

endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rdhs_fetch.sv
module rdhs_fetch
    import rdhs_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          far_ack,
    input  logic          far_rdy,
    input  logic [DW-1:0] lines_in,
    output logic          read_req,
    output logic          ack_out,
    output logic          drive,
    output logic [DW-1:0] drive_val,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rd_data
);
    fetch_state_t state, nxt;
    logic [1:0]    sync_q;
    logic          ack_s, rdy_s, quiet;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] word_q;
    logic          done_q;

    rdhs_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({far_ack, far_rdy}),
        .q     (sync_q)
    );
    assign ack_s = sync_q[1];
    assign rdy_s = sync_q[0];
    assign quiet = !ack_s && !rdy_s;

    always_comb begin
        nxt = state;
        unique case (state)
            FT_IDLE: if (start && quiet) nxt = FT_ADDR;   // accept
            FT_ADDR: if (ack_s)          nxt = FT_WAIT;   // addr_acked
            FT_WAIT: if (rdy_s)          nxt = FT_ACK;    // data_seen
            FT_ACK:  if (!rdy_s)         nxt = FT_IDLE;   // rdy_gone
            default:                     nxt = FT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= FT_IDLE;
            addr_q <= '0;
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= (state == FT_ACK) && !rdy_s;
            if (state == FT_IDLE && start && quiet) addr_q <= start_addr;
            if (state == FT_WAIT && rdy_s)          word_q <= lines_in;
        end
    end

    always_comb begin
        read_req  = (state == FT_ADDR);
        drive     = (state == FT_ADDR);
        ack_out   = (state == FT_ACK);
        drive_val = DW'(addr_q);
        ready     = (state == FT_IDLE) && quiet;
        done      = done_q;
        rd_data   = word_q;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (read_req && !ack_s) |=> read_req);                              // R3
    AST_START_ON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_req) |-> $past(quiet));                               // R9
    AST_ACK_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> $past(rdy_s));                                // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R8
endmodule

// File: rtl/rdhs_store.sv
module rdhs_store
    import rdhs_pkg::*;
#(
    parameter int          AW   = 4,
    parameter int          DW   = 8,
    parameter int          WW   = 4,
    parameter logic [7:0]  SEED = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          far_req,
    input  logic          far_ack,
    input  logic [DW-1:0] lines_in,
    input  logic [WW-1:0] access_wait,
    output logic          ack_out,
    output logic          data_rdy,
    output logic          drive,
    output logic [DW-1:0] drive_val
);
    localparam int DEPTH = 1 << AW;

    store_state_t  state, nxt;
    logic [1:0]    sync_q;
    logic          req_s, ack_s;
    logic [AW-1:0] addr_q;
    logic [WW-1:0] cnt_q;
    logic [DW-1:0] word_q;
    logic [DW-1:0] contents [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            assign contents[i] = DW'(i) ^ DW'(SEED);
        end
    endgenerate

    rdhs_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({far_req, far_ack}),
        .q     (sync_q)
    );
    assign req_s = sync_q[1];
    assign ack_s = sync_q[0];

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_s)       nxt = ST_ACK;     // req_seen
            ST_ACK:    if (!req_s)      nxt = ST_ACCESS;  // req_gone
            ST_ACCESS: if (cnt_q == '0) nxt = ST_DRIVE;   // count_done
            ST_DRIVE:  if (ack_s)       nxt = ST_IDLE;    // data_acked
            default:                    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            cnt_q  <= '0;
            word_q <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE:   if (req_s)  addr_q <= lines_in[AW-1:0];
                ST_ACK:    if (!req_s) cnt_q  <= access_wait;
                ST_ACCESS: begin
                    if (cnt_q == '0) word_q <= contents[addr_q];
                    else             cnt_q  <= cnt_q - 1'b1;
                end
                ST_DRIVE:  ;
                default:   ;
            endcase
        end
    end

    always_comb begin
        ack_out   = (state == ST_ACK);
        data_rdy  = (state == ST_DRIVE);
        drive     = (state == ST_DRIVE);
        drive_val = word_q;
    end

    AST_RDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy && !ack_s) |=> data_rdy);                              // R8
    AST_DATA_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rdy) |-> !req_s);                                     // R6
    AST_ACK_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> $past(req_s));                                // R4
endmodule

// File: rtl/rdhs_link.sv
module rdhs_link #(
    parameter int         AW   = 4,
    parameter int         DW   = 8,
    parameter int         WW   = 4,
    parameter logic [7:0] SEED = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [WW-1:0] access_wait,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          read_req,
    output logic          ack,
    output logic          data_rdy,
    output logic          req_drive,
    output logic          rsp_drive,
    output logic [DW-1:0] bus_lines
);
    logic          fetch_ack, store_ack;
    logic [DW-1:0] fetch_val, store_val;

    rdhs_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .far_ack    (store_ack),
        .far_rdy    (data_rdy),
        .lines_in   (bus_lines),
        .read_req   (read_req),
        .ack_out    (fetch_ack),
        .drive      (req_drive),
        .drive_val  (fetch_val),
        .ready      (ready),
        .done       (done),
        .rd_data    (rd_data)
    );

    rdhs_store #(.AW(AW), .DW(DW), .WW(WW), .SEED(SEED)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .far_req     (read_req),
        .far_ack     (fetch_ack),
        .lines_in    (bus_lines),
        .access_wait (access_wait),
        .ack_out     (store_ack),
        .data_rdy    (data_rdy),
        .drive       (rsp_drive),
        .drive_val   (store_val)
    );

    always_comb begin
        if (req_drive)      bus_lines = fetch_val;
        else if (rsp_drive) bus_lines = store_val;
        else                bus_lines = '0;
    end

    assign ack = fetch_ack | store_ack;

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_drive && rsp_drive));                                      // R2
    AST_ACKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_ack && store_ack));                                      // R5
endmodule

// File: tb/rdhs_link_test.sv
module rdhs_link_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [WW-1:0] access_wait = '0;
    logic          ready, done, read_req, ack, data_rdy, req_drive, rsp_drive;
    logic [DW-1:0] rd_data, bus_lines;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // timeline model: t = edges since acceptance, -1 when nothing accepted yet
    int            t = -1;
    int            w_cur = 0;
    logic [AW-1:0] a_cur = '0;
    logic [DW-1:0] exp_rd = '0;

    always #4 clk = ~clk;   // 125 MHz

    rdhs_link #(.AW(AW), .DW(DW), .WW(WW), .SEED(8'hA5)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .access_wait(access_wait), .ready(ready), .done(done), .rd_data(rd_data),
        .read_req(read_req), .ack(ack), .data_rdy(data_rdy),
        .req_drive(req_drive), .rsp_drive(rsp_drive), .bus_lines(bus_lines)
    );

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return DW'(a) ^ 8'hA5;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0d", req, what, act, exp, t);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            t = -1;
            exp_rd = '0;
        end else begin
            if ((t < 0 || t >= 19 + w_cur) && start) begin
                t = 0;
                w_cur = int'(access_wait);
                a_cur = start_addr;
            end else if (t >= 0 && t < 100000) begin
                t++;
            end
            if (t == 13 + w_cur) exp_rd = word_at(a_cur);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit act_on, e_req, e_ack, e_rdy;
            logic [DW-1:0] e_bus;
            act_on = (t >= 0);
            e_req = act_on && t <= 5;
            e_ack = act_on && ((t >= 3 && t <= 8) || (t >= 13 + w_cur && t <= 18 + w_cur));
            e_rdy = act_on && t >= 10 + w_cur && t <= 15 + w_cur;
            e_bus = e_req ? DW'(a_cur) : (e_rdy ? word_at(a_cur) : '0);
            chk("R3", "read_req",  read_req,  e_req);
            chk("R5", "req_drive", req_drive, e_req);
            chk("R4", "ack",       ack,       e_ack);
            chk("R6", "data_rdy",  data_rdy,  e_rdy);
            chk("R8", "rsp_drive", rsp_drive, e_rdy);
            chk("R2", "bus_lines", bus_lines, e_bus);
            chk("R8", "done",      done,      act_on && t == 19 + w_cur);
            chk("R9", "ready",     ready,     !act_on || t >= 19 + w_cur);
            chk("R7", "rd_data",   rd_data,   exp_rd);
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                tests++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                finish_run();
            end
        end
    end

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) return;
        end
        tests++;
        fails++;
        $display("FAIL R8 done never seen actual=0 expected=1");
    endtask

    task automatic one_read(input logic [AW-1:0] a, input logic [WW-1:0] w);
        @(negedge clk);
        start = 1'b1;
        start_addr = a;
        access_wait = w;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R7", "rd_data at done", rd_data, word_at(a));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "read_req", read_req, 0);
        chk("R1", "ack", ack, 0);
        chk("R1", "data_rdy", data_rdy, 0);
        chk("R1", "drives", {req_drive, rsp_drive}, 0);
        chk("R1", "bus_lines", bus_lines, 0);
        chk("R1", "ready", ready, 1);
        chk("R1", "done", done, 0);
        chk("R1", "rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 R10: shortest access
        one_read(4'h3, 4'd0);
        // R10: longest access, top address
        one_read(4'hF, 4'd15);
        one_read(4'h0, 4'd1);

        // R9: extra starts and address changes while busy
        @(negedge clk);
        start = 1'b1; start_addr = 4'h6; access_wait = 4'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; start_addr = 4'hC;
        repeat (3) @(negedge clk);
        start = 1'b0; start_addr = 4'h9;
        wait_done();
        chk("R9", "word of accepted address", rd_data, word_at(4'h6));
        repeat (3) @(negedge clk);

        // R8: start held high, reads run back to back
        start = 1'b1; start_addr = 4'hA; access_wait = 4'd2;
        wait_done();
        chk("R8", "first back-to-back word", rd_data, word_at(4'hA));
        @(negedge clk);
        start_addr = 4'h5;
        wait_done();
        start = 1'b0;
        chk("R8", "second back-to-back word", rd_data, word_at(4'hA));
        repeat (25) @(negedge clk);
        chk("R1", "link quiet at end", {read_req, ack, data_rdy}, 0);
        finish_run();
    end
endmodule